// File: doc/BRIEF.md
# Programmable Pulse Fault Injector

The block sits in series with a single digital wire and corrupts it for a programmable number of cycles in every programmable period. A phase counter produces a periodic window. While the window is open, a two-way selector replaces the clean bit with a fault value: forced low, forced high or the inverted input. While the window is closed, the clean bit passes straight through.

An optional probability gate draws a value from a 16-bit shift-register sequence once per period and keeps that period's window only when the value is below a threshold. This produces intermittent, irregular faults. The gated window is also driven out on a cascade pin. A neighbouring injector can take that pin as its timing source, so clustered faults can be placed on several wires at once.

Configuration is sampled only while the block is disabled and is frozen while it runs. A counter keeps a running total of the corrupted cycles. The wire is a plain level signal rather than a stream, so there is no valid/ready handshake: the output follows the input combinationally in the same cycle, and no back-pressure exists.

Top module: `pulse_fault_injector`

## Requirements
- R1: During and right after reset, `sig_out` equals `sig_in`, `pulse_out` is 0 and `fault_count` is 0.
- R2: While `enable` is 0, `sig_out` equals `sig_in` and `pulse_out` is 0.
- R3: Phases are numbered from 0 at the first enabled cycle. The phase then counts 0..P-1 and wraps. The local window is high in phases 0..W-1, where W is the width and P the period (sampled values).
- R4: With width 0 and the external source not selected, the window never opens and `sig_out` always equals `sig_in`.
- R5: When the width is non-zero and at least the period, the window stays open for every enabled cycle. A period of 0 is treated as 1.
- R6: While the selector is set, the output depends on `cfg_mode`: 0 drives 0, 1 drives 1, and 2 or 3 drive the inverse of `sig_in`.
- R7: Configuration inputs are captured on each clock edge at which `enable` is 0. Changes while `enable` is 1 have no effect until the next disabled cycle.
- R8: With `cfg_prob_en` set, the sequence register is compared against `cfg_threshold` in phase 0, and that period's window is kept only if the register value is less than the threshold. The register is reloaded with seed 0xACE1 while the block is disabled. At each phase 0 it steps to {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R9: `pulse_out` carries the gated local window. With `cfg_ext_sel` set, the selector follows `ext_pulse_in` instead, but only while the block is enabled.
- R10: `fault_count` increases by one after every cycle in which the selector is set, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Run the injector; low loads configuration |
| cfg_width | input | CNT_W | Window length in cycles |
| cfg_period | input | CNT_W | Period length in cycles |
| cfg_mode | input | 2 | Fault value select |
| cfg_prob_en | input | 1 | Enable probability gate |
| cfg_threshold | input | 16 | Probability threshold |
| cfg_ext_sel | input | 1 | Take timing from `ext_pulse_in` |
| ext_pulse_in | input | 1 | Cascaded window from another injector |
| sig_in | input | 1 | Clean signal |
| sig_out | output | 1 | Possibly corrupted signal |
| pulse_out | output | 1 | Gated local window for cascading |
| fault_count | output | CNT_OUT_W | Corrupted-cycle total |

## Verification
Every width from 0 to 5 is crossed with every period from 0 to 5 and all four fault modes. This separates three cases: windows shorter than the period, zero-width windows, and windows that hold the fault continuously. The incoming bit toggles in an irregular pattern, so stuck-at faults can be told apart from inversion.

Threshold runs at 0, 0x4000, 0x8000 and all ones show whether each period is kept or dropped per the sequence. Runs with the external source selected show whether the selector follows the cascade pin while `pulse_out` keeps the local window. Halfway through each run the configuration inputs are scrambled, which shows whether the frozen settings stay in force.

// File: rtl/pfi_pkg.sv
package pfi_pkg;
  typedef enum logic [1:0] {
    FM_LOW   = 2'd0,
    FM_HIGH  = 2'd1,
    FM_FLIP  = 2'd2,
    FM_FLIP2 = 2'd3
  } fault_mode_e;

  localparam int SEQ_W = 16;

  function automatic logic [SEQ_W-1:0] seq_next(input logic [SEQ_W-1:0] s);
    return {s[SEQ_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/pfi_timer.sv
module pfi_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] width,
  input  logic [CNT_W-1:0] period,
  output logic             phase_start,
  output logic             window
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] ph;
  logic [CNT_W-1:0] period_eff;
  logic             last;

  always_comb begin
    period_eff  = (period == '0) ? ONE : period;
    last        = (ph == period_eff - ONE);
    phase_start = run && (ph == '0);
    window      = run && (width != '0) && ((width >= period_eff) || (ph < width));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ph <= '0;
    else if (!run)   ph <= '0;
    else if (last)   ph <= '0;
    else             ph <= ph + ONE;
  end

  // R3: phase stays inside the period
  a_r3_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ph < period_eff));

  // R3: after the last phase a new period begins
  a_r3_wrap_to_start: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(last)) |-> phase_start);
endmodule

// File: rtl/pfi_prob_gate.sv
module pfi_prob_gate
  import pfi_pkg::*;
#(
  parameter logic [SEQ_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             phase_start,
  input  logic             prob_en,
  input  logic [SEQ_W-1:0] threshold,
  output logic             gate
);
  logic [SEQ_W-1:0] seq;
  logic             hold;
  logic             fresh;

  always_comb begin
    fresh = !prob_en || (seq < threshold);
    gate  = phase_start ? fresh : hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq  <= SEED;
      hold <= 1'b1;
    end else if (!run) begin
      seq  <= SEED;
      hold <= 1'b1;
    end else if (phase_start) begin
      seq  <= seq_next(seq);
      hold <= fresh;
    end
  end

  // R8: the sequence never locks up at zero
  a_r8_seq_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    seq != '0);

  // R8: the decision holds for the whole period
  a_r8_gate_per_period: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !phase_start) |-> (gate == $past(gate)));
endmodule

// File: rtl/pfi_fault_mux.sv
module pfi_fault_mux
  import pfi_pkg::*;
(
  input  logic        sel,
  input  fault_mode_e mode,
  input  logic        din,
  output logic        dout
);
  logic fval;

  always_comb begin
    unique case (mode)
      FM_LOW:  fval = 1'b0;
      FM_HIGH: fval = 1'b1;
      default: fval = ~din;
    endcase
    dout = sel ? fval : din;
  end
endmodule

// File: rtl/pulse_fault_injector.sv
module pulse_fault_injector
  import pfi_pkg::*;
#(
  parameter int               CNT_W     = 16,
  parameter int               CNT_OUT_W = 32,
  parameter logic [SEQ_W-1:0] SEED      = 16'hACE1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [CNT_W-1:0]     cfg_width,
  input  logic [CNT_W-1:0]     cfg_period,
  input  logic [1:0]           cfg_mode,
  input  logic                 cfg_prob_en,
  input  logic [SEQ_W-1:0]     cfg_threshold,
  input  logic                 cfg_ext_sel,
  input  logic                 ext_pulse_in,
  input  logic                 sig_in,
  output logic                 sig_out,
  output logic                 pulse_out,
  output logic [CNT_OUT_W-1:0] fault_count
);
  logic [CNT_W-1:0] width_q;
  logic [CNT_W-1:0] period_q;
  fault_mode_e      mode_q;
  logic             prob_en_q;
  logic [SEQ_W-1:0] thr_q;
  logic             ext_sel_q;

  logic phase_start;
  logic window;
  logic gate;
  logic local_pulse;
  logic sel;

  // configuration is frozen while running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q   <= '0;
      period_q  <= '0;
      mode_q    <= FM_LOW;
      prob_en_q <= 1'b0;
      thr_q     <= '0;
      ext_sel_q <= 1'b0;
    end else if (!enable) begin
      width_q   <= cfg_width;
      period_q  <= cfg_period;
      mode_q    <= fault_mode_e'(cfg_mode);
      prob_en_q <= cfg_prob_en;
      thr_q     <= cfg_threshold;
      ext_sel_q <= cfg_ext_sel;
    end
  end

  pfi_timer #(.CNT_W(CNT_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (enable),
    .width       (width_q),
    .period      (period_q),
    .phase_start (phase_start),
    .window      (window)
  );

  pfi_prob_gate #(.SEED(SEED)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (enable),
    .phase_start (phase_start),
    .prob_en     (prob_en_q),
    .threshold   (thr_q),
    .gate        (gate)
  );

  always_comb begin
    local_pulse = window && gate;
    sel         = enable && (ext_sel_q ? ext_pulse_in : local_pulse);
    pulse_out   = local_pulse;
  end

  pfi_fault_mux u_mux (
    .sel  (sel),
    .mode (mode_q),
    .din  (sig_in),
    .dout (sig_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   fault_count <= '0;
    else if (sel) fault_count <= fault_count + 1'b1;
  end

  // R2: idle selector passes the line
  a_r2_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (sig_out == sig_in));

  // R9: nothing is forwarded while disabled
  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !pulse_out);

  // R4: zero width never corrupts
  a_r4_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && width_q == '0 && !ext_sel_q) |-> (sig_out == sig_in));

  // R5: width at least period keeps the window open
  a_r5_continuous: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && width_q != '0 && width_q >= period_q && !prob_en_q) |-> pulse_out);

  // R6: stuck-at modes force the level
  a_r6_stuck_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && mode_q == FM_HIGH) |-> sig_out);

  // R10: counter steps once per corrupted cycle
  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> (fault_count == $past(fault_count) + 1'b1));

  a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(fault_count));
endmodule

// File: tb/pulse_fault_injector_bench.sv
module pulse_fault_injector_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SEED = 16'hACE1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] cfg_width = '0;
  logic [15:0] cfg_period = '0;
  logic [1:0]  cfg_mode = '0;
  logic        cfg_prob_en = 1'b0;
  logic [15:0] cfg_threshold = '0;
  logic        cfg_ext_sel = 1'b0;
  logic        ext_pulse_in = 1'b0;
  logic        sig_in = 1'b0;
  logic        sig_out;
  logic        pulse_out;
  logic [31:0] fault_count;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // bench model state
  int          m_ph = 0;
  logic [15:0] m_seq = SEED;
  logic        m_hold = 1'b1;
  int          m_w = 0, m_p = 0, m_mode = 0;
  logic        m_pen = 1'b0, m_xs = 1'b0;
  logic [15:0] m_thr = '0;
  int          m_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_fault_injector u_pulse_fault_injector (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_width(cfg_width), .cfg_period(cfg_period), .cfg_mode(cfg_mode),
    .cfg_prob_en(cfg_prob_en), .cfg_threshold(cfg_threshold),
    .cfg_ext_sel(cfg_ext_sel), .ext_pulse_in(ext_pulse_in),
    .sig_in(sig_in), .sig_out(sig_out), .pulse_out(pulse_out),
    .fault_count(fault_count)
  );

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // called just after a falling edge with inputs already applied
  task automatic tick(input string tag);
    int pe;
    logic start, fresh, g, loc, sel, fv, eo;
    #1;
    pe    = (m_p == 0) ? 1 : m_p;
    start = enable && (m_ph == 0);
    fresh = !m_pen || (m_seq < m_thr);
    g     = start ? fresh : m_hold;
    loc   = enable && (m_w != 0) && ((m_w >= pe) || (m_ph < m_w)) && g;
    sel   = enable && (m_xs ? ext_pulse_in : loc);
    fv    = (m_mode == 0) ? 1'b0 : (m_mode == 1) ? 1'b1 : ~sig_in;
    eo    = sel ? fv : sig_in;
    chk({tag, " sig_out R6"}, int'(sig_out), int'(eo));
    chk({tag, " pulse_out R9"}, int'(pulse_out), int'(loc));
    chk({tag, " fault_count R10"}, int'(fault_count), m_count);
    if (!enable) begin
      m_ph = 0; m_seq = SEED; m_hold = 1'b1;
    end else begin
      m_ph = (m_ph + 1 >= pe) ? 0 : m_ph + 1;
      if (start) begin
        m_seq = nxt(m_seq); m_hold = fresh;
      end
    end
    if (sel) m_count++;
    if (!enable) begin
      m_w = int'(cfg_width); m_p = int'(cfg_period); m_mode = int'(cfg_mode);
      m_pen = cfg_prob_en; m_thr = cfg_threshold; m_xs = cfg_ext_sel;
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic run_cfg(input int w, input int p, input int mode, input logic pen,
                         input logic [15:0] thr, input logic xs, input int n, input string tag);
    enable = 1'b0;
    cfg_width = 16'(w); cfg_period = 16'(p); cfg_mode = 2'(mode);
    cfg_prob_en = pen; cfg_threshold = thr; cfg_ext_sel = xs;
    sig_in = cyc[0]; tick("R2 disabled");
    sig_in = ~cyc[1]; tick("R2 disabled");
    enable = 1'b1;
    for (int i = 0; i < n; i++) begin
      sig_in = cyc[0] ^ cyc[2];
      ext_pulse_in = cyc[1] ^ cyc[3];
      if (i == n / 2) begin
        // R7: scrambled configuration while running must be ignored
        cfg_width = 16'(w + 3); cfg_period = 16'(p + 1); cfg_mode = 2'(mode + 1);
        cfg_prob_en = ~pen; cfg_threshold = ~thr; cfg_ext_sel = ~xs;
      end
      tick(i >= n / 2 ? {tag, " R7"} : tag);
    end
  endtask

  initial begin
    sig_in = 1'b1;
    #(CLK_PERIOD * 2 + 1);
    checks++; if (sig_out !== 1'b1) begin errors++; $display("FAIL R1 sig_out actual=%0b expected=1", sig_out); end
    checks++; if (pulse_out !== 1'b0) begin errors++; $display("FAIL R1 pulse_out actual=%0b expected=0", pulse_out); end
    checks++; if (fault_count !== 32'd0) begin errors++; $display("FAIL R1 fault_count actual=%0d expected=0", fault_count); end
    @(negedge clk);
    rst_n = 1'b1;
    tick("R1 after reset");

    for (int w = 0; w <= 5; w++)
      for (int p = 0; p <= 5; p++)
        for (int m = 0; m < 4; m++) begin
          int pe;
          string t;
          pe = (p == 0) ? 1 : p;
          t = (w == 0) ? "R4" : (w >= pe) ? "R5" : "R3";
          run_cfg(w, p, m, 1'b0, 16'h0, 1'b0, 3 * pe + 5, t);
        end

    run_cfg(16'hFFFF, 16'hFFFE, 2, 1'b0, 16'h0, 1'b0, 12, "R5 large");
    run_cfg(3, 0, 1, 1'b0, 16'h0, 1'b0, 8, "R5 period zero");

    run_cfg(2, 3, 1, 1'b1, 16'h0000, 1'b0, 60, "R8 thr0");
    run_cfg(2, 3, 1, 1'b1, 16'h4000, 1'b0, 90, "R8 quarter");
    run_cfg(2, 4, 2, 1'b1, 16'h8000, 1'b0, 120, "R8 half");
    run_cfg(1, 2, 0, 1'b1, 16'hFFFF, 1'b0, 60, "R8 full");

    run_cfg(0, 4, 1, 1'b0, 16'h0, 1'b1, 30, "R9 ext");
    run_cfg(2, 5, 2, 1'b0, 16'h0, 1'b1, 30, "R9 ext local");

    enable = 1'b0; ext_pulse_in = 1'b1; cfg_ext_sel = 1'b1;
    tick("R2 ext while off");
    tick("R2 ext while off");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule